// File: doc/BRIEF.md
# Prefix-Based Immediate Extender

This block widens the short immediate field carried by ordinary instructions into a full data word. Ordinary instructions hold a 5-bit unsigned constant, which on its own reaches values 0 to 31 and, used as a direct-memory address, only the first 32 words. A dedicated prefix instruction carries an 11-bit payload that the block stores. The next ordinary instruction then sees the stored payload as the upper eleven bits and its own 5-bit field as the lower five bits of a 16-bit word. It can use that word as a signed or unsigned constant, or as an address anywhere in the 16-bit space.

A single armed flag records that a stored payload is waiting. The flag is set by a prefix instruction and dropped when the next ordinary instruction reports completion, so one prefix widens exactly one instruction. The output is formed combinationally from the current instruction field, the stored payload and the flag, and it holds steady for the whole execute cycle. The block recognises the prefix opcode. All other decoding belongs to the surrounding control logic.

Top module: `imm_prefix_extender`

## Requirements
- R1: While `rst_n` is low and after it rises, the armed flag `ext_o` is 0 and the upper 11 bits of `imm_o` are 0.
- R2: With the flag clear, `imm_o` equals zero in bits 15..5 and `instr_i[4:0]` in bits 4..0, so a bare field reaches only values 0 to 31.
- R3: A prefix load happens at a rising clock edge where `pfx_stb_i` is 1 and `instr_i[15:11]` equals 5'b11111. The load stores `instr_i[10:0]` and sets `ext_o` to 1 from that edge on.
- R4: With the flag set, `imm_o` equals the stored 11-bit payload in bits 15..5 and `instr_i[4:0]` in bits 4..0. No sign extension is applied, so the full range 0 to 0xFFFF is reachable.
- R5: At a rising edge where `done_stb_i` is 1 and no prefix load occurs, `ext_o` goes to 0. The following instruction sees zero upper bits.
- R6: Two prefix loads in a row make the second payload replace the first, and `ext_o` stays 1.
- R7: At edges with neither a prefix load nor `done_stb_i`, `ext_o` and the stored payload keep their values, so a widened instruction may span several cycles.
- R8: A `pfx_stb_i` pulse while `instr_i[15:11]` differs from 5'b11111 loads nothing. The stored payload and flag stay unchanged, and the pulse clears the flag if `done_stb_i` is also 1.
- R9: When `pfx_stb_i` (with a matching opcode) and `done_stb_i` are both 1 at an edge, the load takes priority and `ext_o` is 1 afterwards.
- R10: `imm_o[4:0]` follows a change of `instr_i[4:0]` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word in execute |
| pfx_stb_i | input | 1 | Strobe: the current instruction is executing as a prefix |
| done_stb_i | input | 1 | Strobe: the current instruction completes at this edge |
| imm_o | output | 16 | Effective immediate or direct-memory address |
| ext_o | output | 1 | Armed flag: a stored payload widens the current instruction |

## Verification
The bench targets the one-shot nature of the prefix. It covers a completion that must disarm the flag, a prefix that completes in the same cycle it loads, and a multi-cycle instruction that must keep the payload across cycles without a completion pulse. A design that cleared on any edge, or let completion win over a load, would show zero upper bits where the reference still holds the payload. Back-to-back prefixes, a prefix strobe carrying a foreign opcode, and the extreme words 0x0000 and 0xFFFF are also applied. These catch designs that merge payloads, load on a bad opcode, or sign-extend the 5-bit field. A mid-cycle change of the low field checks that the output is combinational rather than registered.

// File: rtl/imm_prefix_pkg.sv
package imm_prefix_pkg;

   // How a prefix load is qualified.
   typedef enum logic {
      PFX_QUAL_STROBE = 1'b0,   // strobe alone loads
      PFX_QUAL_OPCODE = 1'b1    // strobe and matching opcode load
   } pfx_qual_e;

   localparam int unsigned DEF_INSTR_W = 16;
   localparam int unsigned DEF_WORD_W  = 16;
   localparam int unsigned DEF_FIELD_W = 5;
   localparam int unsigned DEF_OPC_W   = 5;

   // Fixed-width join of payload and field (both zero-padded by caller).
   function automatic logic [DEF_WORD_W-1:0] join_word(
      input logic [DEF_WORD_W-DEF_FIELD_W-1:0] hi,
      input logic [DEF_FIELD_W-1:0]            lo);
      return {hi, lo};
   endfunction

endpackage

// File: rtl/imm_prefix_decode.sv
module imm_prefix_decode
   import imm_prefix_pkg::*;
#(
   parameter int unsigned OPC_W    = DEF_OPC_W,
   parameter logic [OPC_W-1:0] OPC_VAL = '1,
   parameter pfx_qual_e   QUAL     = PFX_QUAL_OPCODE
) (
   input  logic [OPC_W-1:0] opc_i,
   input  logic             pfx_stb_i,
   output logic             load_o,
   output logic             opc_hit_o
);

   generate
      if (QUAL == PFX_QUAL_OPCODE) begin : g_opc
         assign opc_hit_o = (opc_i == OPC_VAL);
      end else begin : g_stb
         logic unused_opc;
         assign unused_opc = ^opc_i;
         assign opc_hit_o  = 1'b1;
      end
   endgenerate

   assign load_o = pfx_stb_i & opc_hit_o;

endmodule

// File: rtl/imm_prefix_state.sv
module imm_prefix_state #(
   parameter int unsigned PFX_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             done_i,
   input  logic [PFX_W-1:0] payload_i,
   output logic [PFX_W-1:0] pfx_q_o,
   output logic             armed_o
);

   logic [PFX_W-1:0] pfx_q;
   logic             armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pfx_q <= '0;
      end else if (load_i) begin
         pfx_q <= payload_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (load_i) begin
         armed_q <= 1'b1;
      end else if (done_i) begin
         armed_q <= 1'b0;
      end
   end

   assign pfx_q_o = pfx_q;
   assign armed_o = armed_q;

   // R3 / R6: a load stores the payload and arms the flag
   p_load_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (armed_q && pfx_q == $past(payload_i)));

   // R5: completion without a load disarms
   p_done_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !load_i) |=> !armed_q);

   // R7: idle edges keep both flag and payload
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_i && !load_i) |=> ($stable(armed_q) && $stable(pfx_q)));

endmodule

// File: rtl/imm_prefix_join.sv
module imm_prefix_join #(
   parameter int unsigned FIELD_W = 5,
   parameter int unsigned PFX_W   = 11
) (
   input  logic [FIELD_W-1:0]       field_i,
   input  logic [PFX_W-1:0]         pfx_i,
   input  logic                     armed_i,
   output logic [PFX_W+FIELD_W-1:0] word_o
);

   logic [PFX_W-1:0] upper;

   always_comb begin
      upper = armed_i ? pfx_i : '0;
   end

   assign word_o = {upper, field_i};

   // R2: without an armed prefix the word never exceeds the short range
   always_comb begin
      if (!armed_i) begin
         p_short_range_r2: assert (word_o < (1 << FIELD_W));
      end
   end

endmodule

// File: rtl/imm_prefix_extender.sv
module imm_prefix_extender
   import imm_prefix_pkg::*;
#(
   parameter int unsigned INSTR_W   = DEF_INSTR_W,
   parameter int unsigned WORD_W    = DEF_WORD_W,
   parameter int unsigned FIELD_W   = DEF_FIELD_W,
   parameter int unsigned FIELD_LSB = 0,
   parameter int unsigned OPC_W     = DEF_OPC_W,
   parameter int unsigned OPC_LSB   = 11,
   parameter int unsigned PAY_LSB   = 0,
   parameter logic [OPC_W-1:0] PFX_OPC = '1,
   parameter pfx_qual_e   QUAL      = PFX_QUAL_OPCODE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic               pfx_stb_i,
   input  logic               done_stb_i,
   output logic [WORD_W-1:0]  imm_o,
   output logic               ext_o
);

   localparam int unsigned PFX_W = WORD_W - FIELD_W;

   generate
      if (FIELD_W == 0 || FIELD_W >= WORD_W) begin : g_bad_field
         $error("field width must be between 1 and WORD_W-1");
      end
      if (FIELD_LSB + FIELD_W > INSTR_W) begin : g_bad_field_pos
         $error("immediate field runs past the instruction word");
      end
      if (PAY_LSB + PFX_W > INSTR_W) begin : g_bad_pay_pos
         $error("prefix payload runs past the instruction word");
      end
      if (OPC_LSB + OPC_W > INSTR_W) begin : g_bad_opc_pos
         $error("prefix opcode runs past the instruction word");
      end
   endgenerate

   logic             load;
   logic             opc_hit;
   logic [PFX_W-1:0] pfx_q;
   logic             armed;

   imm_prefix_decode #(
      .OPC_W   (OPC_W),
      .OPC_VAL (PFX_OPC),
      .QUAL    (QUAL)
   ) u_decode (
      .opc_i     (instr_i[OPC_LSB +: OPC_W]),
      .pfx_stb_i (pfx_stb_i),
      .load_o    (load),
      .opc_hit_o (opc_hit)
   );

   imm_prefix_state #(
      .PFX_W (PFX_W)
   ) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .done_i    (done_stb_i),
      .payload_i (instr_i[PAY_LSB +: PFX_W]),
      .pfx_q_o   (pfx_q),
      .armed_o   (armed)
   );

   imm_prefix_join #(
      .FIELD_W (FIELD_W),
      .PFX_W   (PFX_W)
   ) u_join (
      .field_i (instr_i[FIELD_LSB +: FIELD_W]),
      .pfx_i   (pfx_q),
      .armed_i (armed),
      .word_o  (imm_o)
   );

   assign ext_o = armed;

   // R8: a strobe with a foreign opcode and no completion changes nothing
   p_foreign_opc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pfx_stb_i && !opc_hit && !done_stb_i)
         |=> ($stable(ext_o) && $stable(pfx_q)));

   // R9: a load wins over a simultaneous completion
   p_load_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && done_stb_i) |=> ext_o);

endmodule

// File: tb/imm_prefix_extender_tb_top.sv
module imm_prefix_extender_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr_i = '0;
   logic        pfx_stb_i = 1'b0;
   logic        done_stb_i = 1'b0;
   logic [15:0] imm_o;
   logic        ext_o;

   int vectors = 0;
   int misses  = 0;
   bit finished = 1'b0;

   // reference state
   int ref_pfx = 0;
   bit ref_arm = 1'b0;

   always #5 clk = ~clk;

   imm_prefix_extender dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .instr_i    (instr_i),
      .pfx_stb_i  (pfx_stb_i),
      .done_stb_i (done_stb_i),
      .imm_o      (imm_o),
      .ext_o      (ext_o)
   );

   function automatic logic [15:0] pfx_word(input int payload);
      return {5'b11111, payload[10:0]};
   endfunction

   task automatic compare(input string req);
      int exp_imm;
      exp_imm = (ref_arm ? (ref_pfx << 5) : 0) + int'(instr_i[4:0]);
      vectors++;
      if (imm_o !== exp_imm[15:0] || ext_o !== ref_arm) begin
         misses++;
         $display("FAIL %s: imm=%h ext=%b expected imm=%h ext=%b",
                  req, imm_o, ext_o, exp_imm[15:0], ref_arm);
      end
   endtask

   // Drive one cycle, check mid-cycle, then advance the model at the edge.
   task automatic step(input logic [15:0] ins, input bit ps, input bit ds,
                       input string req);
      @(negedge clk);
      instr_i = ins; pfx_stb_i = ps; done_stb_i = ds;
      #1;
      compare(req);
      @(posedge clk);
      if (ps && ins[15:11] == 5'b11111) begin
         ref_pfx = int'(ins[10:0]);
         ref_arm = 1'b1;
      end else if (ds) begin
         ref_arm = 1'b0;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         misses++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin : stim
      // R1: reset state, field passes through, upper bits zero
      @(negedge clk);
      instr_i = 16'hFFF7;
      pfx_stb_i = 1'b1;
      #1 compare("R1 in reset");
      @(negedge clk);
      @(negedge clk);
      pfx_stb_i = 1'b0;
      rst_n = 1'b1;
      #1 compare("R1 after reset");

      // R2: bare fields, no prefix
      step(16'h001F, 0, 1, "R2 field 31");
      step(16'h0A40, 0, 1, "R2 field 0");
      step(16'h3C15, 0, 1, "R2 field 21");

      // R3/R4: prefix then widened instruction, top of range
      step(pfx_word(11'h7FF), 1, 1, "R3 load 7FF");
      step(16'h001F, 0, 0, "R4 word FFFF");
      step(16'h001F, 0, 1, "R7 held FFFF");
      // R5: consumed, back to short range
      step(16'h0003, 0, 1, "R5 disarmed");

      // R4: payload zero still arms, word zero
      step(pfx_word(0), 1, 1, "R3 load 000");
      step(16'h0000, 0, 1, "R4 word 0000");

      // R6: back-to-back prefixes, second wins
      step(pfx_word(11'h155), 1, 1, "R6 first");
      step(pfx_word(11'h2AA), 1, 1, "R6 second");
      step(16'h0011, 0, 1, "R6 second payload used");
      step(16'h0011, 0, 0, "R5 after consume");

      // R7: multi-cycle instruction keeps the prefix
      step(pfx_word(11'h123), 1, 0, "R3 load no done");
      step(16'h0004, 0, 0, "R7 cycle 1");
      step(16'h0004, 0, 0, "R7 cycle 2");
      step(16'h0004, 0, 1, "R7 cycle 3");
      step(16'h0004, 0, 0, "R5 cleared");

      // R8: foreign opcode with strobe ignored
      step(16'h7ABC, 1, 0, "R8 foreign opc");
      step(16'h0009, 0, 0, "R8 no load seen");
      step(pfx_word(11'h0F0), 1, 1, "R3 load 0F0");
      step(16'hF7FF, 1, 0, "R8 foreign opc armed");
      step(16'h0002, 0, 1, "R8 payload kept");
      step(16'h0002, 0, 0, "R5 cleared again");
      step(pfx_word(11'h0F0), 1, 1, "R3 reload");
      step(16'h8001, 1, 1, "R8 foreign opc with done");
      step(16'h0001, 0, 0, "R8 done cleared");

      // R9: load and done together, load wins
      step(pfx_word(11'h3E1), 1, 1, "R9 load and done");
      step(16'h000E, 0, 1, "R9 armed");

      // R10: combinational low field within a cycle
      step(pfx_word(11'h401), 1, 1, "R3 load 401");
      @(negedge clk);
      instr_i = 16'h0005; pfx_stb_i = 1'b0; done_stb_i = 1'b0;
      #1 compare("R10 before change");
      #2 instr_i = 16'h001A;
      #1 compare("R10 after change");
      @(posedge clk);

      // R2..R9 mixed pseudo-random traffic
      for (int i = 0; i < 400; i++) begin
         logic [15:0] w;
         bit ps;
         bit ds;
         w  = 16'($urandom);
         ps = ($urandom % 3) == 0;
         ds = ($urandom % 2) == 0;
         if (ps && ($urandom % 2) == 0) w[15:11] = 5'b11111;
         step(w, ps, ds, "R2-mix R4 R5 R6 R7 R8 R9");
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule